// File: doc/BRIEF.md
# UART FIFO Programmable Trigger Logic

This block turns the fill levels of a UART channel's 32-entry receive and transmit FIFOs into three threshold events. The host can program a flow-control level, a receive interrupt level and a transmit interrupt level through three 5-bit override registers on a small register bus. An override left at zero falls back to a fixed level that a 2-bit legacy select field picks.

On the receive side the block reports when enough data is waiting: a received-data-available condition, and a request to deassert the RTS line for automatic flow control. On the transmit side it keeps a transmitter-holding-register-empty (THRE) interrupt state. That state is set when the transmit count falls through the programmed level, and also whenever the transmit FIFO drains to empty. A host byte write or a host read of the interrupt identity clears it. The FIFOs, the shifters and the interrupt priority logic sit outside this block.

Top module: `uart_fifo_trigger`

## Requirements
- R1: Three 5-bit override registers are written when `reg_we` is high at a clock edge, at address 0 (flow-control level), 1 (receive interrupt level) and 2 (transmit interrupt level). `reg_rdata` shows, without a clock delay, the register that `reg_addr` selects. Address 3 reads as 0 and ignores writes.
- R2: A synchronous active-high reset clears all override registers, the THRE state and the stored previous transmit count.
- R3: A receive-side override at zero makes the legacy select field choose the level: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R4: `rx_data_avail` is high, without a clock delay, exactly while `rx_count` is greater than or equal to the active receive interrupt level. That level is the override at address 1 if it is non-zero, else the legacy level.
- R5: `rts_deassert_req` is high, without a clock delay, exactly while `rx_count` is greater than or equal to the active flow-control level. That level is the override at address 0 if it is non-zero, else the legacy level. It does not depend on the receive interrupt override.
- R6: When the transmit override T is non-zero, `thre_irq` becomes 1 one cycle after a clock edge at which the sampled `tx_count` equals T and the count sampled at the previous edge was T+1.
- R7: `thre_irq` becomes 1 one cycle after an edge at which the sampled `tx_count` is 0 and the previous sample was non-zero, whatever the transmit override is.
- R8: `thre_irq` clears one cycle after an edge with `tx_write` or `thre_id_read` high. If a set condition (R6, R7) occurs at the same edge, the set wins.
- R9: No other transmit count movement sets `thre_irq`. This includes a fall that jumps past T, a rise onto T, and any crossing while the transmit override is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 flow, 1 rx interrupt, 2 tx interrupt) |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Read data of the addressed register |
| legacy_sel | input | 2 | Legacy receive trigger select |
| rx_count | input | 6 | Receive FIFO fill level, 0 to 32 |
| tx_count | input | 6 | Transmit FIFO fill level, 0 to 32 |
| tx_write | input | 1 | Host wrote a byte to the transmit FIFO |
| thre_id_read | input | 1 | Host read interrupt identity while THRE was reported |
| rx_data_avail | output | 1 | Received-data-available condition |
| rts_deassert_req | output | 1 | Auto-RTS deassert request |
| thre_irq | output | 1 | THRE interrupt state |

## Verification
The bench drives the transmit override to 31 and steps the count from 32 to 31. A design that compares the threshold with a 5-bit counter would wrap and miss that crossing. It jumps the transmit count past the programmed level and steps it upward onto the level; a design that tests only the level, or a fall through it, would raise THRE where it must stay quiet. It puts a set and a host clear on the same edge, which catches a clear-priority design that loses the event. It also drains to empty from below the threshold, and it gives the flow and interrupt levels different values, so a design that shares one override between both receive outputs, or writes the unused address, shows up at the ports.

// File: rtl/ufpt_pkg.sv
package ufpt_pkg;

    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int THR_W      = $clog2(FIFO_DEPTH);
    localparam int NUM_RX_CMP = 2;

    typedef enum logic [1:0] {
        ADDR_FLOW  = 2'd0,
        ADDR_RXINT = 2'd1,
        ADDR_TXINT = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [THR_W-1:0] flow;
        logic [THR_W-1:0] rx_int;
        logic [THR_W-1:0] tx_int;
    } ovr_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] prev_cnt;
        logic             thre;
    } tx_state_t;

    function automatic logic [THR_W-1:0] legacy_level(input logic [1:0] sel);
        logic [THR_W-1:0] lvl;
        case (sel)
            2'd0:    lvl = THR_W'(1);
            2'd1:    lvl = THR_W'(4);
            2'd2:    lvl = THR_W'(8);
            default: lvl = THR_W'(14);
        endcase
        return lvl;
    endfunction

    function automatic logic [THR_W-1:0] pick_level(input logic [THR_W-1:0] ovr,
                                                    input logic [1:0]       sel);
        return (ovr != '0) ? ovr : legacy_level(sel);
    endfunction

endpackage

// File: rtl/ufpt_regs.sv
module ufpt_regs
    import ufpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [THR_W-1:0] wdata,
    output ovr_regs_t        regs,
    output logic [THR_W-1:0] rdata
);

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            case (addr_e)
                ADDR_FLOW:  regs.flow   <= wdata;
                ADDR_RXINT: regs.rx_int <= wdata;
                ADDR_TXINT: regs.tx_int <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (addr_e)
            ADDR_FLOW:  rdata = regs.flow;
            ADDR_RXINT: rdata = regs.rx_int;
            ADDR_TXINT: rdata = regs.tx_int;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ufpt_rx_cmp.sv
module ufpt_rx_cmp
    import ufpt_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] ovr,
    input  logic [1:0]       legacy_sel,
    output logic             hit
);

    logic [THR_W-1:0] level;

    always_comb begin
        level = pick_level(ovr, legacy_sel);
        hit   = count >= CNT_W'(level);
    end

endmodule

// File: rtl/ufpt_tx_thre.sv
module ufpt_tx_thre
    import ufpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [THR_W-1:0] tx_ovr,
    input  logic             tx_write,
    input  logic             thre_id_read,
    output logic             thre
);

    tx_state_t        st_q;
    tx_state_t        st_d;
    logic [CNT_W-1:0] lvl_ext;
    logic             hit_level;
    logic             hit_empty;
    logic             clr;

    always_comb begin
        lvl_ext   = CNT_W'(tx_ovr);
        hit_level = (tx_ovr != '0)
                 && (st_q.prev_cnt == lvl_ext + CNT_W'(1))
                 && (tx_count == lvl_ext);
        hit_empty = (st_q.prev_cnt != '0) && (tx_count == '0);
        clr       = tx_write || thre_id_read;

        st_d.prev_cnt = tx_count;
        if (hit_level || hit_empty)
            st_d.thre = 1'b1;
        else if (clr)
            st_d.thre = 1'b0;
        else
            st_d.thre = st_q.thre;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign thre = st_q.thre;

endmodule

// File: rtl/uart_fifo_trigger.sv
module uart_fifo_trigger
    import ufpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [THR_W-1:0] reg_wdata,
    output logic [THR_W-1:0] reg_rdata,
    input  logic [1:0]       legacy_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_write,
    input  logic             thre_id_read,
    output logic             rx_data_avail,
    output logic             rts_deassert_req,
    output logic             thre_irq
);

    ovr_regs_t              regs;
    logic [THR_W-1:0]       rx_ovr [NUM_RX_CMP];
    logic [NUM_RX_CMP-1:0]  rx_hit;

    ufpt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .regs  (regs),
        .rdata (reg_rdata)
    );

    // index 0: data-available level, index 1: flow-control level
    assign rx_ovr[0] = regs.rx_int;
    assign rx_ovr[1] = regs.flow;

    for (genvar g = 0; g < NUM_RX_CMP; g++) begin : g_rx_cmp
        ufpt_rx_cmp u_cmp (
            .count      (rx_count),
            .ovr        (rx_ovr[g]),
            .legacy_sel (legacy_sel),
            .hit        (rx_hit[g])
        );
    end

    assign rx_data_avail    = rx_hit[0];
    assign rts_deassert_req = rx_hit[1];

    ufpt_tx_thre u_tx (
        .clk          (clk),
        .rst          (rst),
        .tx_count     (tx_count),
        .tx_ovr       (regs.tx_int),
        .tx_write     (tx_write),
        .thre_id_read (thre_id_read),
        .thre         (thre_irq)
    );

endmodule

// File: rtl/ufpt_chk.sv
module ufpt_chk
    import ufpt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [THR_W-1:0] reg_wdata,
    input logic [THR_W-1:0] reg_rdata,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_write,
    input logic             thre_id_read,
    input logic             rx_data_avail,
    input logic             rts_deassert_req,
    input logic             thre_irq
);

    logic past_ok;
    logic past_ok2;

    always_ff @(posedge clk) begin
        past_ok  <= !rst;
        past_ok2 <= !rst && past_ok;
    end

    AST_REG_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != 2'd3) |=>
            (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata))); // R1

    AST_RDA_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> !rx_data_avail); // R4

    AST_RDA_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_count == CNT_W'(FIFO_DEPTH)) |-> rx_data_avail); // R4

    AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> !rts_deassert_req); // R5

    AST_RTS_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_count == CNT_W'(FIFO_DEPTH)) |-> rts_deassert_req); // R5

    AST_THRE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (past_ok && tx_count == '0 && $past(tx_count) != '0) |=> thre_irq); // R7

    AST_THRE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(thre_irq)) |-> $past(tx_write || thre_id_read)); // R8

    AST_THRE_SET_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (past_ok2 && $rose(thre_irq)) |-> ($past(tx_count) < $past(tx_count, 2))); // R9

endmodule

bind uart_fifo_trigger ufpt_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .reg_we           (reg_we),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .reg_rdata        (reg_rdata),
    .rx_count         (rx_count),
    .tx_count         (tx_count),
    .tx_write         (tx_write),
    .thre_id_read     (thre_id_read),
    .rx_data_avail    (rx_data_avail),
    .rts_deassert_req (rts_deassert_req),
    .thre_irq         (thre_irq)
);

// File: tb/uart_fifo_trigger_tb.sv
module uart_fifo_trigger_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [4:0] reg_wdata = 5'd0;
    logic [4:0] reg_rdata;
    logic [1:0] legacy_sel = 2'd0;
    logic [5:0] rx_count = 6'd0;
    logic [5:0] tx_count = 6'd0;
    logic       tx_write = 1'b0;
    logic       thre_id_read = 1'b0;
    logic       rx_data_avail;
    logic       rts_deassert_req;
    logic       thre_irq;

    int tests = 0;
    int fails = 0;

    // bench model state
    int m_ovr [3];
    int m_prev = 0;
    int m_thre = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_trigger u_dut (
        .clk              (clk),
        .rst              (rst),
        .reg_we           (reg_we),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .legacy_sel       (legacy_sel),
        .rx_count         (rx_count),
        .tx_count         (tx_count),
        .tx_write         (tx_write),
        .thre_id_read     (thre_id_read),
        .rx_data_avail    (rx_data_avail),
        .rts_deassert_req (rts_deassert_req),
        .thre_irq         (thre_irq)
    );

    function automatic int legacy_of(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int active_of(input int ovr, input int sel);
        return (ovr != 0) ? ovr : legacy_of(sel);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called right after inputs change on a falling edge
    task automatic tick();
        int rda_tag_lvl;
        #1;
        rda_tag_lvl = active_of(m_ovr[1], legacy_sel);
        chk("R4 rx_data_avail", rx_data_avail, (rx_count >= rda_tag_lvl) ? 1 : 0);
        chk("R5 rts_deassert_req", rts_deassert_req,
            (rx_count >= active_of(m_ovr[0], legacy_sel)) ? 1 : 0);
        chk("R1 reg_rdata", reg_rdata, (reg_addr == 2'd3) ? 0 : m_ovr[reg_addr]);
        @(posedge clk);
        begin
            bit set_ev;
            set_ev = (m_ovr[2] != 0 && m_prev == m_ovr[2] + 1 && tx_count == m_ovr[2])
                  || (m_prev != 0 && tx_count == 0);
            if (set_ev) m_thre = 1;
            else if (tx_write || thre_id_read) m_thre = 0;
            m_prev = tx_count;
            if (reg_we && reg_addr != 2'd3) m_ovr[reg_addr] = reg_wdata;
        end
        @(negedge clk);
        chk("R6/R7/R8/R9 thre_irq", thre_irq, m_thre);
        reg_we       = 1'b0;
        tx_write     = 1'b0;
        thre_id_read = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 5'(d);
        tick();
    endtask

    task automatic set_tx(input int n);
        tx_count = 6'(n);
        tick();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_ovr[i] = 0;
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        chk("R2 thre_irq after reset", thre_irq, 0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            chk("R2 override reset value", reg_rdata, 0);
        end
        reg_addr = 2'd0;

        // R3: legacy levels with zero overrides
        for (int s = 0; s < 4; s++) begin
            legacy_sel = 2'(s);
            rx_count = 6'(legacy_of(s) - 1);
            tick();
            chk("R3 below legacy level", rx_data_avail, 0);
            rx_count = 6'(legacy_of(s));
            tick();
            chk("R3 at legacy level", rts_deassert_req, 1);
        end

        // R1: unused address ignores writes, others unaffected
        wr(0, 7); wr(1, 20); wr(2, 9);
        wr(3, 31);
        reg_addr = 2'd3; tick();
        reg_addr = 2'd0; tick();
        chk("R1 flow reg after addr3 write", reg_rdata, 7);

        // R5: flow level independent from rx interrupt level
        legacy_sel = 2'd3;
        rx_count = 6'd10;
        tick();
        chk("R5 flow at 7, rx at 10", rts_deassert_req, 1);
        chk("R4 rx level 20 not reached", rx_data_avail, 0);

        // R6: level 31, count 32 -> 31
        wr(2, 31);
        set_tx(32);
        set_tx(31);
        chk("R6 crossing 32->31", thre_irq, 1);
        tx_write = 1'b1; tick();
        chk("R8 cleared by write", thre_irq, 0);

        // R9: jump past level and rise onto level, level 10
        wr(2, 10);
        set_tx(12); set_tx(10);
        chk("R9 jump 12->10 no set", thre_irq, 0);
        set_tx(9); set_tx(10);
        chk("R9 rise onto level no set", thre_irq, 0);

        // R8: set and clear on the same edge, set wins
        set_tx(11);
        tx_count = 6'd10; tx_write = 1'b1; tick();
        chk("R8 set wins over clear", thre_irq, 1);
        thre_id_read = 1'b1; tick();
        chk("R8 cleared by id read", thre_irq, 0);

        // R7: drain to empty from below the level
        set_tx(3); set_tx(0);
        chk("R7 drain below level", thre_irq, 1);
        thre_id_read = 1'b1; tick();

        // R9: override zero disables level crossing
        wr(2, 0);
        set_tx(5); set_tx(4);
        chk("R9 zero override no crossing", thre_irq, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            int t;
            r = int'($urandom % 16);
            if (r == 0) begin
                reg_we = 1'b1;
                reg_addr = 2'($urandom % 4);
                reg_wdata = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom % 32);
            end
            if (r == 1) legacy_sel = 2'($urandom % 4);
            t = int'(tx_count);
            case ($urandom % 8)
                0, 1, 2: t = t - 1;
                3, 4:    t = t + 1;
                5:       t = int'($urandom % (DEPTH + 1));
                default: ;
            endcase
            if (t < 0) t = 0;
            if (t > DEPTH) t = DEPTH;
            tx_count = 6'(t);
            rx_count = 6'($urandom % (DEPTH + 1));
            tx_write = ($urandom % 12 == 0);
            thre_id_read = ($urandom % 12 == 0);
            tick();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule